// File: doc/BRIEF.md
# Converter Serial Result Shifter

This block is the serial readout stage of a 12-bit sampling converter. It keeps the most recently completed result in a shift register and sends it out one bit at a time, most significant bit first. The conversion sequencer supplies a busy level, which is low while a conversion runs and rises when the result is ready. It also supplies a chip-select, a read/convert level, a clock-source selector and the 12-bit result word.

The block has two clocking modes. In internal mode the start of a conversion launches a burst of exactly twelve pulses on a data clock output. The burst comes from a parameterised divider of the system clock. The result of the previous conversion travels on the serial line during that burst, and the read/convert input plays no part. In external mode a receiver owns the data clock. Selecting a read raises a one-cycle frame marker, and each falling edge of the incoming clock then advances the word by one bit, so the receiver samples on the rising edges. The bit shifted into the bottom of the register comes from a chain input. Several devices can therefore be cascaded so that one clock stream reads all of their words back to back.

The end of a conversion copies the new word into the shift register. In external mode, if the incoming clock is high at that moment, the copy is dropped and a sticky loss flag is raised.

Top module: `serial_result_shifter`

## Requirements
- R1: After reset the shift register holds zero, the loss flag, frame marker and data clock output are low, so the first internal burst sends twelve zero bits.
- R2: In internal mode (extMode=0) a falling edge of busyIn starts a burst of exactly 12 pulses on dataClkOut. Each pulse is low for DIV_HALF and then high for DIV_HALF system cycles. sdataOut carries the word held before the burst, MSB first, and stays constant while dataClkOut is high.
- R3: In internal mode with csN held low, changing rdConvN during a burst does not alter the bits sent.
- R4: In external mode (extMode=1) the start of a read (csN low with rdConvN high) drives syncOut high for exactly one system cycle, in the cycle after the select is first sampled.
- R5: In external mode the MSB is on sdataOut before the first clock. Each synchronised falling edge of dataClkIn during a read moves the next lower bit onto sdataOut, so that the value seen just before rising edge r (r = 1..12) is word bit 12−r.
- R6: In external mode the value seen just before rising edge r, for r > 12, equals the level of tagIn held across the falling edge that follows rising edge r−12.
- R7: A rising edge of busyIn copies resultIn into the shift register. In external mode, if the synchronised dataClkIn is high at that edge, the copy is skipped and lostFlag goes high and stays high until reset.
- R8: sdataOe is low whenever csN is high. It is high when csN is low in internal mode, and when csN is low with rdConvN high in external mode.
- R9: In external mode, edges on dataClkIn while no read is selected leave sdataOut unchanged.
- R10: When the serial output of one instance feeds the tagIn of a second, 24 external clocks read the second word and then the first word, each MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busyIn | input | 1 | Low during a conversion, rises when the result is ready |
| csN | input | 1 | Active-low chip select |
| rdConvN | input | 1 | High selects read, low selects convert |
| extMode | input | 1 | 1 for an external data clock, 0 for an internal burst |
| resultIn | input | WORD_W | Completed conversion result |
| dataClkIn | input | 1 | External data clock (asynchronous) |
| tagIn | input | 1 | Chain input, shifted in below the word in external mode |
| dataClkOut | output | 1 | Internally generated data clock |
| sdataOut | output | 1 | Serial data, MSB first |
| sdataOe | output | 1 | Output enable for the serial data line |
| syncOut | output | 1 | One-cycle frame marker at the start of an external read |
| lostFlag | output | 1 | Sticky flag for a result dropped at busy rise |

## Verification
The bench builds the block with WORD_W=12, DIV_HALF=3 and SYNC_DEPTH=2. The short half period keeps a full 12-pulse internal burst within about 72 cycles, so several random conversions fit in one run, and a bit-by-bit capture can check that the data stays stable while the data clock is high. The external clock is driven with a 12-cycle period, which is longer than the three-cycle synchroniser and edge-detect path. This lets the bench drive the chain input at a known time and check the 12-clock latency exactly. The same setting supports two cascaded instances and a deliberate high clock level at busy rise.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef struct packed {
    logic loadWord;
    logic shiftWord;
    logic shiftIn;
  } dpStrobe_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stages;

  generate
    if (DEPTH == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages <= '0;
        else       stages <= d;
      end
    end else begin : gMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages <= '0;
        else       stages <= {stages[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = stages[DEPTH-1];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int DIV_HALF   = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busyIn,
  input  logic      csN,
  input  logic      rdConvN,
  input  logic      extMode,
  input  logic      dataClkIn,
  input  logic      tagIn,
  output dpStrobe_t strobe,
  output logic      dataClkOut,
  output logic      syncOut,
  output logic      sdataOe,
  output logic      lostFlag
);
  localparam int SLOT  = 2 * DIV_HALF;
  localparam int DIV_W = (SLOT > 2) ? $clog2(SLOT) : 1;
  localparam int BIT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [DIV_W-1:0] SLOT_LAST = DIV_W'(SLOT - 1);
  localparam logic [DIV_W-1:0] HALF_MARK = DIV_W'(DIV_HALF);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);

  logic busyQ, busyRise, busyFall;
  logic clkSyncQ, clkPrevQ, extFall;
  logic tagSyncQ;
  logic readSel, readQ;
  logic txActive;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic intShift, extShift;

  srs_sync #(.DEPTH(SYNC_DEPTH)) clkSync (
    .clk(clk), .rstN(rstN), .d(dataClkIn), .q(clkSyncQ)
  );
  srs_sync #(.DEPTH(SYNC_DEPTH)) tagSync (
    .clk(clk), .rstN(rstN), .d(tagIn), .q(tagSyncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b1;
      clkPrevQ <= 1'b0;
    end else begin
      busyQ    <= busyIn;
      clkPrevQ <= clkSyncQ;
    end
  end

  assign busyRise = busyIn & ~busyQ;
  assign busyFall = ~busyIn & busyQ;
  assign extFall  = clkPrevQ & ~clkSyncQ;
  assign readSel  = ~csN & rdConvN;

  // Internal burst: WORD_W slots of SLOT system cycles each
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else if (busyFall && !extMode) begin
      txActive <= 1'b1;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else if (txActive) begin
      if (divCnt == SLOT_LAST) begin
        divCnt <= '0;
        if (bitCnt == BIT_LAST) txActive <= 1'b0;
        else                    bitCnt   <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign intShift   = txActive && (divCnt == SLOT_LAST);
  assign extShift   = extMode && readSel && extFall;
  assign dataClkOut = txActive && (divCnt >= HALF_MARK);

  always_comb begin
    strobe.loadWord  = busyRise && !(extMode && clkSyncQ);
    strobe.shiftWord = intShift || extShift;
    strobe.shiftIn   = extMode ? tagSyncQ : 1'b0;
  end

  // Frame marker and loss flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readQ    <= 1'b0;
      syncOut  <= 1'b0;
      lostFlag <= 1'b0;
    end else begin
      readQ   <= extMode & readSel;
      syncOut <= extMode & readSel & ~readQ;
      if (busyRise && extMode && clkSyncQ) lostFlag <= 1'b1;
    end
  end

  assign sdataOe = ~csN & (~extMode | rdConvN);
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] wordIn,
  output logic              sdataOut
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobe.loadWord)  shiftReg <= wordIn;
    else if (strobe.shiftWord) shiftReg <= {shiftReg[WORD_W-2:0], strobe.shiftIn};
  end

  assign sdataOut = shiftReg[WORD_W-1];
endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
  import srs_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int DIV_HALF   = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic              csN,
  input  logic              rdConvN,
  input  logic              extMode,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              dataClkIn,
  input  logic              tagIn,
  output logic              dataClkOut,
  output logic              sdataOut,
  output logic              sdataOe,
  output logic              syncOut,
  output logic              lostFlag
);
  dpStrobe_t strobe;

  srs_ctrl #(
    .WORD_W(WORD_W), .DIV_HALF(DIV_HALF), .SYNC_DEPTH(SYNC_DEPTH)
  ) ctrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .csN(csN), .rdConvN(rdConvN),
    .extMode(extMode), .dataClkIn(dataClkIn), .tagIn(tagIn), .strobe(strobe),
    .dataClkOut(dataClkOut), .syncOut(syncOut), .sdataOe(sdataOe),
    .lostFlag(lostFlag)
  );

  srs_datapath #(.WORD_W(WORD_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(resultIn),
    .sdataOut(sdataOut)
  );
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busyIn,
  input logic              csN,
  input logic              rdConvN,
  input logic              extMode,
  input logic [WORD_W-1:0] resultIn,
  input logic              dataClkOut,
  input logic              sdataOut,
  input logic              sdataOe,
  input logic              syncOut,
  input logic              lostFlag
);
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> !syncOut); // R4

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lostFlag |=> lostFlag); // R7

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !$past(busyIn) && !extMode) |=> (sdataOut == $past(resultIn[WORD_W-1]))); // R7

  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sdataOe); // R8

  AST_EXT_NO_BURST: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> !dataClkOut); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && (csN || !rdConvN) && !(busyIn && !$past(busyIn))) |=> $stable(sdataOut)); // R9
endmodule

bind serial_result_shifter srs_checker #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .busyIn(busyIn), .csN(csN), .rdConvN(rdConvN),
  .extMode(extMode), .resultIn(resultIn), .dataClkOut(dataClkOut),
  .sdataOut(sdataOut), .sdataOe(sdataOe), .syncOut(syncOut), .lostFlag(lostFlag)
);

// File: tb/serial_result_shifter_test.sv
module serial_result_shifter_test;
  localparam int WORD_W   = 12;
  localparam int DIV_HALF = 3;
  localparam int EXT_H    = 6;
  localparam int CONV_CYC = 2 * DIV_HALF * WORD_W + 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busy = 1'b1, csN = 1'b1, rdConvN = 1'b0, extMode = 1'b0;
  logic dataClkIn = 1'b0, tagDrv = 1'b0;
  logic [WORD_W-1:0] resA = '0, resB = '0;
  logic clkOutA, sdataA, oeA, syncA, lostA;
  logic clkOutB, sdataB, oeB, syncB, lostB;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic tagHist [0:31];

  always #5 clk = ~clk;

  serial_result_shifter #(.WORD_W(WORD_W), .DIV_HALF(DIV_HALF), .SYNC_DEPTH(2)) uut (
    .clk(clk), .rstN(rstN), .busyIn(busy), .csN(csN), .rdConvN(rdConvN),
    .extMode(extMode), .resultIn(resA), .dataClkIn(dataClkIn), .tagIn(tagDrv),
    .dataClkOut(clkOutA), .sdataOut(sdataA), .sdataOe(oeA), .syncOut(syncA),
    .lostFlag(lostA)
  );

  serial_result_shifter #(.WORD_W(WORD_W), .DIV_HALF(DIV_HALF), .SYNC_DEPTH(2)) uutB (
    .clk(clk), .rstN(rstN), .busyIn(busy), .csN(csN), .rdConvN(rdConvN),
    .extMode(extMode), .resultIn(resB), .dataClkIn(dataClkIn), .tagIn(sdataA),
    .dataClkOut(clkOutB), .sdataOut(sdataB), .sdataOe(oeB), .syncOut(syncB),
    .lostFlag(lostB)
  );

  function automatic logic bitOf(input logic [WORD_W-1:0] w, input int pos);
    return w[WORD_W-1-pos];
  endfunction

  function automatic logic [WORD_W-1:0] randWord();
    return WORD_W'($urandom);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Internal burst: busy low for CONV_CYC, capture bits, then load nextWord.
  task automatic intConvert(input logic [WORD_W-1:0] nextWord,
                            input logic [WORD_W-1:0] expWord,
                            input bit toggleRc, input string req);
    logic [WORD_W-1:0] captured;
    int pulses;
    logic prevClk, prevData;
    bit unstable, oeBad;
    captured = '0; pulses = 0; prevClk = 1'b0; prevData = 1'b0;
    unstable = 0; oeBad = 0;
    @(negedge clk);
    busy = 1'b0;
    for (int i = 0; i < CONV_CYC; i++) begin
      @(negedge clk);
      if (clkOutA && !prevClk) begin
        captured = {captured[WORD_W-2:0], sdataA};
        pulses++;
      end
      if (clkOutA && prevClk && (sdataA !== prevData)) unstable = 1;
      if (oeA !== 1'b1) oeBad = 1;
      prevClk = clkOutA;
      prevData = sdataA;
      if (toggleRc) rdConvN = 1'($urandom);
    end
    resA = nextWord;
    busy = 1'b1;
    @(negedge clk);
    rdConvN = 1'b1;
    check({req, " burst word"}, int'(captured), int'(expWord));
    check("R2 pulse count", pulses, WORD_W);
    check("R2 data stable while clock high", int'(unstable), 0);
    check("R8 enable in internal mode", int'(oeBad), 0);
  endtask

  task automatic extPulse(input logic tagV);
    dataClkIn = 1'b1;
    tagDrv = tagV;
    repeat (EXT_H) @(negedge clk);
    dataClkIn = 1'b0;
    repeat (EXT_H) @(negedge clk);
  endtask

  task automatic loadBoth(input logic [WORD_W-1:0] wa, input logic [WORD_W-1:0] wb);
    @(negedge clk);
    busy = 1'b0;
    repeat (3) @(negedge clk);
    resA = wa;
    resB = wb;
    busy = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [WORD_W-1:0] prevWord, w, wa, wb, w3, w4;
    logic held;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sdata after reset", int'(sdataA), 0);
    check("R1 sync after reset", int'(syncA), 0);
    check("R1 lost after reset", int'(lostA), 0);
    check("R1 data clock after reset", int'(clkOutA), 0);
    check("R8 enable with cs high", int'(oeA), 0);

    // Internal mode
    csN = 1'b0;
    rdConvN = 1'b1;
    extMode = 1'b0;
    w = randWord();
    intConvert(w, '0, 1'b0, "R1 first burst zero");
    prevWord = w;
    for (int k = 0; k < 5; k++) begin
      w = (k == 0) ? 12'hFFF : (k == 1) ? 12'hA5A : randWord();
      intConvert(w, prevWord, (k >= 2), (k >= 2) ? "R3 rc toggled" : "R2");
      prevWord = w;
    end

    // External mode, two chained instances
    csN = 1'b1;
    rdConvN = 1'b0;
    extMode = 1'b1;
    repeat (4) @(negedge clk);
    wa = randWord();
    wb = randWord();
    loadBoth(wa, wb);
    check("R7 no loss with clock low", int'(lostA), 0);
    csN = 1'b0;
    rdConvN = 1'b1;
    @(negedge clk);
    check("R4 sync high", int'(syncA), 1);
    check("R4 sync high chained", int'(syncB), 1);
    check("R8 enable on read", int'(oeA), 1);
    @(negedge clk);
    check("R4 sync one cycle", int'(syncA), 0);
    check("R5 msb before clock", int'(sdataA), int'(bitOf(wa, 0)));
    for (int r = 1; r <= 2 * WORD_W; r++) begin
      logic tv;
      if (r <= WORD_W) begin
        check("R5 bit", int'(sdataA), int'(bitOf(wa, r - 1)));
        check("R10 chain own bit", int'(sdataB), int'(bitOf(wb, r - 1)));
      end else begin
        check("R6 tag latency", int'(sdataA), int'(tagHist[r - WORD_W]));
        check("R10 chain upstream bit", int'(sdataB), int'(bitOf(wa, r - WORD_W - 1)));
      end
      tv = 1'($urandom);
      tagHist[r] = tv;
      extPulse(tv);
    end

    // R9 clocks while not selected
    held = sdataA;
    csN = 1'b1;
    repeat (3) extPulse(~held);
    check("R9 cs high ignores clock", int'(sdataA), int'(held));
    check("R8 enable off with cs high", int'(oeA), 0);
    csN = 1'b0;
    rdConvN = 1'b0;
    repeat (2) extPulse(~held);
    check("R9 convert level ignores clock", int'(sdataA), int'(held));
    check("R8 enable off in convert", int'(oeA), 0);

    // R7 loss when clock high at busy rise
    csN = 1'b1;
    w3 = randWord();
    w4 = ~w3;
    loadBoth(w3, w3);
    check("R7 flag clear after good load", int'(lostA), 0);
    dataClkIn = 1'b1;
    repeat (5) @(negedge clk);
    loadBoth(w4, w4);
    check("R7 flag set", int'(lostA), 1);
    check("R7 flag set chained", int'(lostB), 1);
    dataClkIn = 1'b0;
    repeat (5) @(negedge clk);
    loadBoth(randWord(), randWord());
    check("R7 flag sticky", int'(lostA), 1);
    // that last load succeeded; read it and confirm the dropped word never arrived
    w = resA;
    csN = 1'b0;
    rdConvN = 1'b1;
    repeat (3) @(negedge clk);
    begin
      logic [WORD_W-1:0] got;
      got = '0;
      for (int r = 0; r < WORD_W; r++) begin
        got = {got[WORD_W-2:0], sdataA};
        extPulse(1'b0);
      end
      check("R7 later good load read", int'(got), int'(w));
    end

    // Dropped word check: reload with clock low, then try a drop and read back
    csN = 1'b1;
    rdConvN = 1'b0;
    w3 = 12'h3C6;
    loadBoth(w3, w3);
    dataClkIn = 1'b1;
    repeat (5) @(negedge clk);
    loadBoth(12'hC39, 12'hC39);
    dataClkIn = 1'b0;
    repeat (5) @(negedge clk);
    csN = 1'b0;
    rdConvN = 1'b1;
    repeat (3) @(negedge clk);
    begin
      logic [WORD_W-1:0] got;
      got = '0;
      for (int r = 0; r < WORD_W; r++) begin
        got = {got[WORD_W-2:0], sdataA};
        extPulse(1'b0);
      end
      check("R7 dropped word keeps old", int'(got), int'(w3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule